// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of ownership latches shared between a left port and a right port. Software on either side uses a latch to claim a shared resource. Writing 0 asks for the latch, and writing 1 gives it up or withdraws a request. Reading a latch tells the port whether it currently holds it.

If a port asks for a latch while the other side holds it, the request is not lost. It is stored and turned into ownership in the same cycle that the holder lets go. Each port sees its own view of a latch: 0 when it holds the latch, 1 otherwise.

A port's access counts only while its semaphore select is high and its memory enable is low. Read results are registered on every data line and stay unchanged until that port makes its next read.

Top module: `dual_sem_bank`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) leaves every latch free with no stored request, and drives both read outputs to all ones.
- R2: The index selects one of `N_SEM` latches (8 by default). An operation on one index never changes any other latch.
- R3: A write of 0 to a free latch makes the writing port its owner. The owner then reads all zeros and the other port reads all ones. At most one port owns a latch at any time.
- R4: A write of 0 to a latch the other port owns does not change the owner. The requester keeps reading all ones, and its request is stored as pending.
- R5: When the owner writes 1 and the other port has a pending request, the other port owns the latch after that clock edge and its pending request is cleared.
- R6: A write of 0 by the current owner changes nothing. A write of 1 by a port that neither owns the latch nor has a request pending leaves the latch unchanged.
- R7: A write of 1 by a port with a pending request cancels that request. A later release by the owner then leaves the latch free.
- R8: Both ports may operate in the same cycle. The left operation is applied first and the right operation is applied to the result. Two requests for the same free latch in one cycle therefore give ownership to the left port and leave the right request pending.
- R9: A read (select high, memory enable low, write low) loads the port's output register with all zeros if the port owns the addressed latch and all ones otherwise. The value is taken from the state before that edge, so a write by the other port in the same cycle does not affect it. The output holds until the port's next read.
- R10: An access with select low, or with memory enable high, has no effect on any latch or on the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel | input | 1 | Left semaphore select |
| a_mem_en | input | 1 | Left memory enable; blocks semaphore access when high |
| a_wr | input | 1 | Left write strobe (1 write, 0 read) |
| a_wbit | input | 1 | Left write bit (0 request, 1 release) |
| a_idx | input | $clog2(N_SEM) | Left latch index |
| a_rdata | output | DATA_W | Left registered read result |
| b_sel | input | 1 | Right semaphore select |
| b_mem_en | input | 1 | Right memory enable; blocks semaphore access when high |
| b_wr | input | 1 | Right write strobe |
| b_wbit | input | 1 | Right write bit |
| b_idx | input | $clog2(N_SEM) | Right latch index |
| b_rdata | output | DATA_W | Right registered read result |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset is applied from time zero. From these they conclude that the state never has two owners and never has a pending request without an opposing owner. The bench changes inputs only on falling edges and starts in reset. Its random phase draws every combination of select, memory enable, write and index, including same-index collisions, so the assertion premises are met while all operation orderings are covered.

// File: rtl/dual_sem_bank.sv
module dual_sem_bank #(
  parameter int N_SEM  = 8,
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(N_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_mem_en,
  input  logic              a_wr,
  input  logic              a_wbit,
  input  logic [IW-1:0]     a_idx,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_sel,
  input  logic              b_mem_en,
  input  logic              b_wr,
  input  logic              b_wbit,
  input  logic [IW-1:0]     b_idx,
  output logic [DATA_W-1:0] b_rdata
);

  logic [N_SEM-1:0] own_a, own_b, pend_a, pend_b;
  logic [N_SEM-1:0] nx_own_a, nx_own_b, nx_pend_a, nx_pend_b;

  wire a_go = a_sel & ~a_mem_en;
  wire b_go = b_sel & ~b_mem_en;

  always_comb begin
    nx_own_a  = own_a;
    nx_own_b  = own_b;
    nx_pend_a = pend_a;
    nx_pend_b = pend_b;
    if (a_go && a_wr) begin
      if (!a_wbit) begin
        if (nx_own_b[a_idx]) nx_pend_a[a_idx] = 1'b1;
        else                 nx_own_a[a_idx]  = 1'b1;
      end else begin
        nx_pend_a[a_idx] = 1'b0;
        if (nx_own_a[a_idx]) begin
          nx_own_a[a_idx]  = 1'b0;
          nx_own_b[a_idx]  = nx_pend_b[a_idx];
          nx_pend_b[a_idx] = 1'b0;
        end
      end
    end
    if (b_go && b_wr) begin
      if (!b_wbit) begin
        if (nx_own_a[b_idx]) nx_pend_b[b_idx] = 1'b1;
        else                 nx_own_b[b_idx]  = 1'b1;
      end else begin
        nx_pend_b[b_idx] = 1'b0;
        if (nx_own_b[b_idx]) begin
          nx_own_b[b_idx]  = 1'b0;
          nx_own_a[b_idx]  = nx_pend_a[b_idx];
          nx_pend_a[b_idx] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_a   <= '0;
      own_b   <= '0;
      pend_a  <= '0;
      pend_b  <= '0;
      a_rdata <= '1;
      b_rdata <= '1;
    end else begin
      own_a  <= nx_own_a;
      own_b  <= nx_own_b;
      pend_a <= nx_pend_a;
      pend_b <= nx_pend_b;
      if (a_go && !a_wr) a_rdata <= {DATA_W{~own_a[a_idx]}};
      if (b_go && !b_wr) b_rdata <= {DATA_W{~own_b[b_idx]}};
    end
  end

endmodule

// File: rtl/dual_sem_bank_chk.sv
module dual_sem_bank_chk #(
  parameter int N_SEM  = 8,
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(N_SEM)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_sel,
  input logic              a_mem_en,
  input logic              a_wr,
  input logic              a_wbit,
  input logic [IW-1:0]     a_idx,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_sel,
  input logic              b_mem_en,
  input logic              b_wr,
  input logic              b_wbit,
  input logic [IW-1:0]     b_idx,
  input logic [DATA_W-1:0] b_rdata,
  input logic [N_SEM-1:0]  own_a,
  input logic [N_SEM-1:0]  own_b,
  input logic [N_SEM-1:0]  pend_a,
  input logic [N_SEM-1:0]  pend_b
);

  wire a_go = a_sel && !a_mem_en;
  wire b_go = b_sel && !b_mem_en;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (own_a == '0 && own_b == '0 && pend_a == '0 && pend_b == '0
                      && a_rdata == '1 && b_rdata == '1));

  p_single_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_a & own_b) == '0);

  p_pend_needs_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_a & ~own_b) | (pend_b & ~own_a)) == '0);

  p_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_go && a_wr && a_wbit && own_a[a_idx] && pend_b[a_idx] && !b_go)
    |=> (own_b[$past(a_idx)] && !pend_b[$past(a_idx)]));

  p_left_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_go && b_go && a_wr && b_wr && !a_wbit && !b_wbit && a_idx == b_idx
     && !own_a[a_idx] && !own_b[a_idx])
    |=> (own_a[$past(a_idx)] && pend_b[$past(a_idx)]));

  p_rd_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rdata == '0 || a_rdata == '1) && (b_rdata == '0 || b_rdata == '1));

  p_rd_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_go && !a_wr) |=> $stable(a_rdata));

  p_rd_hold_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_go && !b_wr) |=> $stable(b_rdata));

  p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_go && !b_go) |=> ($stable(own_a) && $stable(own_b)
                          && $stable(pend_a) && $stable(pend_b)));

endmodule

bind dual_sem_bank dual_sem_bank_chk #(.N_SEM(N_SEM), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_sel(a_sel), .a_mem_en(a_mem_en), .a_wr(a_wr), .a_wbit(a_wbit),
  .a_idx(a_idx), .a_rdata(a_rdata),
  .b_sel(b_sel), .b_mem_en(b_mem_en), .b_wr(b_wr), .b_wbit(b_wbit),
  .b_idx(b_idx), .b_rdata(b_rdata),
  .own_a(own_a), .own_b(own_b), .pend_a(pend_a), .pend_b(pend_b)
);

// File: tb/sim_dual_sem_bank.sv
`timescale 1ns/1ps
module sim_dual_sem_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sel = 0, a_mem_en = 0, a_wr = 0, a_wbit = 0;
  logic b_sel = 0, b_mem_en = 0, b_wr = 0, b_wbit = 0;
  logic [2:0] a_idx = 0, b_idx = 0;
  logic [7:0] a_rdata, b_rdata;

  always #2.5 clk = ~clk;

  dual_sem_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_mem_en(a_mem_en), .a_wr(a_wr), .a_wbit(a_wbit),
    .a_idx(a_idx), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_mem_en(b_mem_en), .b_wr(b_wr), .b_wbit(b_wbit),
    .b_idx(b_idx), .b_rdata(b_rdata)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  int holder [8];
  bit want_l [8];
  bit want_r [8];
  logic [7:0] exp_a = 8'hFF, exp_b = 8'hFF;

  task automatic model_write(input int side, input int k, input bit v);
    int other = (side == 1) ? 2 : 1;
    if (!v) begin
      if (holder[k] == 0) holder[k] = side;
      else if (holder[k] == other) begin
        if (side == 1) want_l[k] = 1; else want_r[k] = 1;
      end
    end else begin
      if (side == 1) want_l[k] = 0; else want_r[k] = 0;
      if (holder[k] == side) begin
        holder[k] = 0;
        if (side == 1 && want_r[k]) begin holder[k] = 2; want_r[k] = 0; end
        if (side == 2 && want_l[k]) begin holder[k] = 1; want_l[k] = 0; end
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (a_rdata !== exp_a) begin
      errors++;
      $display("FAIL %s left read: got %h expected %h", tag, a_rdata, exp_a);
    end
    checks++;
    if (b_rdata !== exp_b) begin
      errors++;
      $display("FAIL %s right read: got %h expected %h", tag, b_rdata, exp_b);
    end
  endtask

  task automatic cyc(input bit as, input bit am, input bit aw, input bit ad, input int ai,
                     input bit bs, input bit bm, input bit bw, input bit bd, input int bi);
    a_sel = as; a_mem_en = am; a_wr = aw; a_wbit = ad; a_idx = 3'(ai);
    b_sel = bs; b_mem_en = bm; b_wr = bw; b_wbit = bd; b_idx = 3'(bi);
    @(posedge clk);
    if (as && !am && !aw) exp_a = (holder[ai] == 1) ? 8'h00 : 8'hFF;
    if (bs && !bm && !bw) exp_b = (holder[bi] == 2) ? 8'h00 : 8'hFF;
    if (as && !am && aw) model_write(1, ai, ad);
    if (bs && !bm && bw) model_write(2, bi, bd);
    @(negedge clk);
    compare();
  endtask

  task automatic lw(input int i, input bit v); cyc(1,0,1,v,i, 0,0,0,0,0); endtask
  task automatic rw(input int i, input bit v); cyc(0,0,0,0,0, 1,0,1,v,i); endtask
  task automatic rd(input int i);              cyc(1,0,0,0,i, 1,0,0,0,i); endtask
  task automatic idle();                       cyc(0,0,0,0,0, 0,0,0,0,0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin holder[k] = 0; want_l[k] = 0; want_r[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; compare();
    for (int k = 0; k < 8; k++) rd(k);

    tag = "R3"; lw(2, 0); rd(2);
    tag = "R2"; rd(3); rd(1);
    tag = "R4"; rw(2, 0); rd(2);
    tag = "R5"; lw(2, 1); rd(2);
    tag = "R6"; rw(2, 0); rd(2); lw(5, 1); rd(5); rw(5, 1); rd(5);
    tag = "R7"; lw(2, 0); lw(2, 1); rw(2, 1); rd(2);
    tag = "R8"; cyc(1,0,1,0,4, 1,0,1,0,4); rd(4); lw(4, 1); rd(4);
    tag = "R9"; cyc(1,0,1,0,4, 1,0,0,0,4); idle(); idle(); rd(4);
    cyc(1,0,0,0,4, 1,0,1,1,4); idle(); rd(4);
    tag = "R10"; cyc(1,1,1,0,6, 0,0,1,0,6); rd(6);
    cyc(1,1,0,0,4, 1,1,0,0,6); rd(6);

    tag = "R9";
    for (int n = 0; n < 3000; n++)
      cyc($urandom_range(0,3) != 0, $urandom_range(0,5) == 0, $urandom_range(0,1) == 1,
          $urandom_range(0,1) == 1, $urandom_range(0,7),
          $urandom_range(0,3) != 0, $urandom_range(0,5) == 0, $urandom_range(0,1) == 1,
          $urandom_range(0,1) == 1, $urandom_range(0,7));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule